// File: doc/BRIEF.md
# Virtual Address Access Gate

This block sits between a processor's load/store address and the memory system. For every request it decides among three outcomes. The address can go through untranslated, be mapped to a physical address using the page entry the translation buffer found, or be stopped with a classified exception. The buffer storage and its search are outside the block: the result of the search arrives on input pins together with the request. That result is hit, miss or multiple hit, plus the page size, the permission flags and the physical frame of the matching entry. The block gives the search unit one hint back: whether address-space identifiers should be ignored for the current request.

The decision is registered. A response appears one clock after the request and lasts one cycle. A fault raises a single-cycle strobe with one exception code. A multiple hit is also flagged as reset-class. On the faults that software repairs (miss, protection and first write), the block captures the faulting address in a fault-address register. It also overwrites the page-number part of a page-entry-high register and keeps that register's low ten bits. Those low bits can be loaded through a plain write port.

Top module: `mmu_access_gate`

## Requirements
- R1: In privileged mode an address at or above 0xE0000000 passes unchanged (rsp_kind 0 = pass).
- R2: In privileged mode an address from 0x80000000 to 0xBFFFFFFF passes with bits 31:29 cleared.
- R3: In user mode an address with bit 31 set gives exc_code 1 for a read or 2 for a write (rsp_kind 2 = fault). The exception is an address in 0xE0000000..0xE3FFFFFF while cfg_sq_lock is 0: that address passes unchanged.
- R4: With cfg_xlate_en at 0, every address not settled by R1 to R3 passes with bits 31:29 cleared.
- R5: lookup_any_asid is high, in the same cycle, exactly when cfg_sv_any_asid and req_priv are both high.
- R6: With translation enabled, both tlb_hit and tlb_multi low is a miss: exc_code 3 for a read, 4 for a write. tlb_multi high gives exc_code 5 with exc_reset_class high. Address errors take priority over these, and these take priority over R7 to R9.
- R7: A user-mode read of an entry whose tlb_user flag is 0 gives exc_code 6.
- R8: A privileged write needs tlb_wr. A user-mode write needs both tlb_user and tlb_wr. A write that fails this gives exc_code 7.
- R9: A write that R8 permits, to an entry whose tlb_dirty is 0, gives exc_code 8.
- R10: A permitted access is translated (rsp_kind 1) to (tlb_ppn AND mask) OR (req_vaddr AND NOT mask). The mask clears the low 10, 12, 16 or 20 bits for tlb_size 0, 1, 2 or 3.
- R11: On exc_code 3, 4, 6, 7 or 8, fault_vaddr takes the full address. pte_hi bits 31:10 take the address bits 31:10 and pte_hi bits 9:0 are kept. Other outcomes leave both registers alone; pte_wr_en loads pte_hi when no such fault occurs in the same cycle.
- R12: Reset clears every output register. Each request yields rsp_valid for exactly one cycle, one clock later, with exactly one code: exc_code 0 and no strobe for pass/translate, a nonzero code and a one-cycle exc_strobe for a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_priv | input | 1 | 1 = privileged mode |
| cfg_xlate_en | input | 1 | Address translation enabled |
| cfg_sv_any_asid | input | 1 | Privileged lookups ignore the address-space identifier |
| cfg_sq_lock | input | 1 | 1 = user-mode store-queue window closed |
| tlb_hit | input | 1 | Search found exactly one entry |
| tlb_multi | input | 1 | Search found more than one entry |
| tlb_size | input | 2 | Page size code of the entry |
| tlb_user | input | 1 | Entry allows user access |
| tlb_wr | input | 1 | Entry allows writes |
| tlb_dirty | input | 1 | Entry dirty flag |
| tlb_ppn | input | 32 | Physical frame of the entry |
| pte_wr_en | input | 1 | Load pte_hi |
| pte_wr_data | input | 32 | Value for pte_hi |
| lookup_any_asid | output | 1 | Hint to the search unit: skip identifier match |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 pass, 1 translate, 2 fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| exc_strobe | output | 1 | Exception pulse |
| exc_code | output | 4 | Exception class |
| exc_reset_class | output | 1 | Exception is reset-class (multiple hit) |
| fault_vaddr | output | 32 | Captured faulting address |
| pte_hi | output | 32 | Page-entry-high register |

## Verification
The assertions take for granted that tlb_hit and tlb_multi are never high together. They also assume that the lookup inputs are valid in the same cycle as req_valid, and that pte_wr_en is not raised in the cycle of a repairable fault. The sweep keeps to these assumptions. It drives the lookup result as one of ten legal cases: miss, multiple hit, or a single hit with each of the eight combinations of user, write and dirty flags. It exercises pte_wr_en only outside the request stream.

// File: rtl/mmu_gate_pkg.sv
package mmu_gate_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_LSB  = 10;
  localparam int SIZE_W    = 2;
  localparam int NUM_SIZES = 1 << SIZE_W;
  localparam int STRIP_W   = 3;
  localparam int SQ_W      = 6;
  localparam logic [STRIP_W-1:0] HI_PASS_PFX = 3'b111;
  localparam logic [SQ_W-1:0]    SQ_WIN_PFX  = 6'b111000;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_XLATE = 2'd1,
    KIND_FAULT = 2'd2
  } rsp_kind_e;

  typedef enum logic [3:0] {
    EXC_NONE     = 4'd0,
    EXC_RD_ADDR  = 4'd1,
    EXC_WR_ADDR  = 4'd2,
    EXC_RD_MISS  = 4'd3,
    EXC_WR_MISS  = 4'd4,
    EXC_MULTI    = 4'd5,
    EXC_RD_PROT  = 4'd6,
    EXC_WR_PROT  = 4'd7,
    EXC_FIRST_WR = 4'd8
  } exc_code_e;

  function automatic int page_shift(input int size_code);
    case (size_code)
      0:       page_shift = 10;
      1:       page_shift = 12;
      2:       page_shift = 16;
      default: page_shift = 20;
    endcase
  endfunction
endpackage

// File: rtl/mmu_region_decode.sv
module mmu_region_decode
  import mmu_gate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic            priv,
  input  logic            xlate_en,
  input  logic            sq_lock,
  output logic            bypass,
  output logic            addr_err,
  output logic [VA_W-1:0] bypass_addr
);
  logic [VA_W-1:0] stripped;
  logic            top_bit;
  logic            hi_region;
  logic            low_kernel;
  logic            sq_window;

  assign stripped   = {{STRIP_W{1'b0}}, vaddr[VA_W-STRIP_W-1:0]};
  assign top_bit    = vaddr[VA_W-1];
  assign hi_region  = (vaddr[VA_W-1 -: STRIP_W] == HI_PASS_PFX);
  assign low_kernel = (vaddr[VA_W-1 -: 2] == 2'b10);
  assign sq_window  = (vaddr[VA_W-1 -: SQ_W] == SQ_WIN_PFX);

  always_comb begin
    bypass      = 1'b0;
    addr_err    = 1'b0;
    bypass_addr = '0;
    if (top_bit && priv && hi_region) begin
      bypass      = 1'b1;
      bypass_addr = vaddr;
    end else if (top_bit && priv && low_kernel) begin
      bypass      = 1'b1;
      bypass_addr = stripped;
    end else if (top_bit && !priv) begin
      if (sq_window && !sq_lock) begin
        bypass      = 1'b1;
        bypass_addr = vaddr;
      end else begin
        addr_err = 1'b1;
      end
    end else if (!xlate_en) begin
      bypass      = 1'b1;
      bypass_addr = stripped;
    end
  end
endmodule

// File: rtl/mmu_page_map.sv
module mmu_page_map
  import mmu_gate_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code,
  input  logic [VA_W-1:0]   ppn,
  input  logic [VA_W-1:0]   vaddr,
  output logic [VA_W-1:0]   paddr
);
  logic [VA_W-1:0] mask_tab [NUM_SIZES];
  logic [VA_W-1:0] mask;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    assign mask_tab[g] = {VA_W{1'b1}} << page_shift(g);
  end

  assign mask  = mask_tab[size_code];
  assign paddr = (ppn & mask) | (vaddr & ~mask);
endmodule

// File: rtl/mmu_perm_eval.sv
module mmu_perm_eval
  import mmu_gate_pkg::*;
(
  input  logic      is_write,
  input  logic      priv,
  input  logic      hit,
  input  logic      multi,
  input  logic      ent_user,
  input  logic      ent_wr,
  input  logic      ent_dirty,
  output exc_code_e code
);
  logic wr_denied;

  assign wr_denied = priv ? !ent_wr : !(ent_user && ent_wr);

  always_comb begin
    if (!hit && !multi)            code = is_write ? EXC_WR_MISS : EXC_RD_MISS;
    else if (multi)                code = EXC_MULTI;
    else if (!is_write)            code = (!priv && !ent_user) ? EXC_RD_PROT : EXC_NONE;
    else if (wr_denied)            code = EXC_WR_PROT;
    else if (!ent_dirty)           code = EXC_FIRST_WR;
    else                           code = EXC_NONE;
  end
endmodule

// File: rtl/mmu_access_gate.sv
module mmu_access_gate
  import mmu_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              cfg_xlate_en,
  input  logic              cfg_sv_any_asid,
  input  logic              cfg_sq_lock,
  input  logic              tlb_hit,
  input  logic              tlb_multi,
  input  logic [1:0]        tlb_size,
  input  logic              tlb_user,
  input  logic              tlb_wr,
  input  logic              tlb_dirty,
  input  logic [31:0]       tlb_ppn,
  input  logic              pte_wr_en,
  input  logic [31:0]       pte_wr_data,
  output logic              lookup_any_asid,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [31:0]       rsp_paddr,
  output logic              exc_strobe,
  output logic [3:0]        exc_code,
  output logic              exc_reset_class,
  output logic [31:0]       fault_vaddr,
  output logic [31:0]       pte_hi
);
  logic            rg_bypass;
  logic            rg_err;
  logic [VA_W-1:0] rg_addr;
  logic [VA_W-1:0] xl_addr;
  exc_code_e       pe_code;
  exc_code_e       code_n;
  rsp_kind_e       kind_n;
  logic [VA_W-1:0] paddr_n;
  logic            repair_fault_n;

  logic            rsp_valid_q, exc_strobe_q, reset_cls_q;
  logic [1:0]      rsp_kind_q;
  logic [3:0]      exc_code_q;
  logic [VA_W-1:0] rsp_paddr_q, fault_vaddr_q, pte_hi_q;

  mmu_region_decode u_region (
    .vaddr       (req_vaddr),
    .priv        (req_priv),
    .xlate_en    (cfg_xlate_en),
    .sq_lock     (cfg_sq_lock),
    .bypass      (rg_bypass),
    .addr_err    (rg_err),
    .bypass_addr (rg_addr)
  );

  mmu_perm_eval u_perm (
    .is_write  (req_write),
    .priv      (req_priv),
    .hit       (tlb_hit),
    .multi     (tlb_multi),
    .ent_user  (tlb_user),
    .ent_wr    (tlb_wr),
    .ent_dirty (tlb_dirty),
    .code      (pe_code)
  );

  mmu_page_map u_map (
    .size_code (tlb_size),
    .ppn       (tlb_ppn),
    .vaddr     (req_vaddr),
    .paddr     (xl_addr)
  );

  assign lookup_any_asid = cfg_sv_any_asid & req_priv;

  // next-state
  always_comb begin
    if (rg_err)         code_n = req_write ? EXC_WR_ADDR : EXC_RD_ADDR;
    else if (rg_bypass) code_n = EXC_NONE;
    else                code_n = pe_code;

    if (code_n != EXC_NONE) kind_n = KIND_FAULT;
    else if (rg_bypass)     kind_n = KIND_PASS;
    else                    kind_n = KIND_XLATE;

    case (kind_n)
      KIND_PASS:  paddr_n = rg_addr;
      KIND_XLATE: paddr_n = xl_addr;
      default:    paddr_n = '0;
    endcase

    repair_fault_n = req_valid &&
                     (code_n == EXC_RD_MISS || code_n == EXC_WR_MISS ||
                      code_n == EXC_RD_PROT || code_n == EXC_WR_PROT ||
                      code_n == EXC_FIRST_WR);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      exc_strobe_q  <= 1'b0;
      reset_cls_q   <= 1'b0;
      rsp_kind_q    <= '0;
      exc_code_q    <= '0;
      rsp_paddr_q   <= '0;
      fault_vaddr_q <= '0;
      pte_hi_q      <= '0;
    end else begin
      rsp_valid_q  <= req_valid;
      exc_strobe_q <= req_valid && (code_n != EXC_NONE);
      reset_cls_q  <= req_valid && (code_n == EXC_MULTI);
      exc_code_q   <= req_valid ? code_n : EXC_NONE;
      if (req_valid) begin
        rsp_kind_q  <= kind_n;
        rsp_paddr_q <= paddr_n;
      end
      if (repair_fault_n) begin
        fault_vaddr_q <= req_vaddr;
        pte_hi_q      <= {req_vaddr[VA_W-1:PAGE_LSB], pte_hi_q[PAGE_LSB-1:0]};
      end else if (pte_wr_en) begin
        pte_hi_q      <= pte_wr_data;
      end
    end
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_kind        = rsp_kind_q;
  assign rsp_paddr       = rsp_paddr_q;
  assign exc_strobe      = exc_strobe_q;
  assign exc_code        = exc_code_q;
  assign exc_reset_class = reset_cls_q;
  assign fault_vaddr     = fault_vaddr_q;
  assign pte_hi          = pte_hi_q;
endmodule

// File: rtl/mmu_access_gate_chk.sv
module mmu_access_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_priv,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic        exc_strobe,
  input logic [3:0]  exc_code,
  input logic        exc_reset_class,
  input logic [31:0] fault_vaddr,
  input logic [31:0] pte_hi
);
  logic repair;
  assign repair = exc_strobe && (exc_code == 4'd3 || exc_code == 4'd4 ||
                  exc_code == 4'd6 || exc_code == 4'd7 || exc_code == 4'd8);

  assert_strobe_has_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> (rsp_valid && exc_code != 4'd0 && rsp_kind == 2'd2));

  assert_clean_no_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != 2'd2) |-> (exc_code == 4'd0 && !exc_strobe));

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_reset_class_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_reset_class |-> (exc_strobe && exc_code == 4'd5));

  assert_addr_err_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (exc_code == 4'd1 || exc_code == 4'd2)) |-> $past(!req_priv));

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !repair |-> $stable(fault_vaddr));

  assert_pte_low_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    repair |-> (pte_hi[9:0] == $past(pte_hi[9:0]) && pte_hi[31:10] == fault_vaddr[31:10]));
endmodule

bind mmu_access_gate mmu_access_gate_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_priv        (req_priv),
  .rsp_valid       (rsp_valid),
  .rsp_kind        (rsp_kind),
  .exc_strobe      (exc_strobe),
  .exc_code        (exc_code),
  .exc_reset_class (exc_reset_class),
  .fault_vaddr     (fault_vaddr),
  .pte_hi          (pte_hi)
);

// File: tb/test_mmu_access_gate.sv
module test_mmu_access_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv;
  logic [31:0] req_vaddr;
  logic        cfg_xlate_en, cfg_sv_any_asid, cfg_sq_lock;
  logic        tlb_hit, tlb_multi, tlb_user, tlb_wr, tlb_dirty;
  logic [1:0]  tlb_size;
  logic [31:0] tlb_ppn;
  logic        pte_wr_en;
  logic [31:0] pte_wr_data;
  logic        lookup_any_asid, rsp_valid, exc_strobe, exc_reset_class;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_paddr, fault_vaddr, pte_hi;
  logic [3:0]  exc_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_access_gate i_mmu_access_gate (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] exp_fault, exp_pte;

  // reference outcome computed from the requirements
  task automatic model(input logic [31:0] a, input bit w, p, at, sql, hit, mul, u, wr, d,
                       input logic [1:0] sz, input logic [31:0] ppn,
                       output logic [1:0] kind, output logic [31:0] pa, output logic [3:0] code,
                       output string tag);
    logic [31:0] strip, mask;
    bit settled;
    strip = {3'b000, a[28:0]};
    settled = 0; kind = 2'd0; pa = 32'h0; code = 4'd0; tag = "R4";
    if (a[31]) begin
      if (p) begin
        if (a >= 32'hE000_0000) begin pa = a; tag = "R1"; settled = 1; end
        else if (a < 32'hC000_0000) begin pa = strip; tag = "R2"; settled = 1; end
      end else begin
        settled = 1; tag = "R3";
        if (a < 32'hE400_0000 && a >= 32'hE000_0000 && !sql) pa = a;
        else begin kind = 2'd2; code = w ? 4'd2 : 4'd1; end
      end
    end
    if (!settled && !at) begin pa = strip; tag = "R4"; settled = 1; end
    if (!settled) begin
      mask = 32'hFFFF_FFFF << (sz == 0 ? 10 : sz == 1 ? 12 : sz == 2 ? 16 : 20);
      kind = 2'd2;
      if (!hit && !mul) begin code = w ? 4'd4 : 4'd3; tag = "R6"; end
      else if (mul) begin code = 4'd5; tag = "R6"; end
      else if (!w && !p && !u) begin code = 4'd6; tag = "R7"; end
      else if (w && (p ? !wr : !(u && wr))) begin code = 4'd7; tag = "R8"; end
      else if (w && !d) begin code = 4'd8; tag = "R9"; end
      else begin kind = 2'd1; code = 4'd0; pa = (ppn & mask) | (a & ~mask); tag = "R10"; end
    end
  endtask

  initial begin
    logic [31:0] addrs [14];
    logic [1:0]  e_kind;
    logic [31:0] e_pa;
    logic [3:0]  e_code;
    string       tag;
    addrs = '{32'h0000_1234, 32'h3FF0_0ABC, 32'h7FFF_FFFC, 32'h8000_0010, 32'hA123_4567,
              32'hBFFF_FFFF, 32'hC000_0400, 32'hDABC_DEF0, 32'hE000_0000, 32'hE3FF_FFFC,
              32'hE400_0000, 32'hFF00_0038, 32'hFFFF_FFFF, 32'h1234_5678};
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_priv = 0; req_vaddr = 0;
    cfg_xlate_en = 0; cfg_sv_any_asid = 0; cfg_sq_lock = 0;
    tlb_hit = 0; tlb_multi = 0; tlb_user = 0; tlb_wr = 0; tlb_dirty = 0;
    tlb_size = 0; tlb_ppn = 0; pte_wr_en = 0; pte_wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    chk("R12", "rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R12", "exc_strobe", {31'b0, exc_strobe}, 0);
    chk("R11", "fault_vaddr", fault_vaddr, 0);
    chk("R11", "pte_hi", pte_hi, 0);
    // load pte_hi through the write port
    @(negedge clk) begin pte_wr_en = 1; pte_wr_data = 32'h155A_A2A5; end
    @(negedge clk) pte_wr_en = 0;
    exp_fault = 32'h0; exp_pte = 32'h155A_A2A5;
    chk("R11", "pte_hi load", pte_hi, exp_pte);
    chk("R12", "idle rsp_valid", {31'b0, rsp_valid}, 0);

    for (int ai = 0; ai < 14; ai++)
      for (int cfg = 0; cfg < 32; cfg++)
        for (int lk = 0; lk < 10; lk++)
          for (int sz = 0; sz < 4; sz++) begin
            @(negedge clk);
            req_valid = 1; req_vaddr = addrs[ai];
            req_write = cfg[0]; req_priv = cfg[1]; cfg_xlate_en = cfg[2];
            cfg_sv_any_asid = cfg[3]; cfg_sq_lock = cfg[4];
            tlb_hit = (lk >= 2); tlb_multi = (lk == 1);
            tlb_user = lk >= 2 ? (((lk - 2) >> 2) & 1) == 1 : 1'b0;
            tlb_wr   = lk >= 2 ? (((lk - 2) >> 1) & 1) == 1 : 1'b0;
            tlb_dirty= lk >= 2 ? ((lk - 2) & 1) == 1 : 1'b0;
            tlb_size = sz[1:0];
            tlb_ppn  = 32'h0C5A_5000 ^ (32'(ai) << 24) ^ 32'h0000_0C00;
            #1;
            chk("R5", "lookup_any_asid", {31'b0, lookup_any_asid}, {31'b0, cfg[3] & cfg[1]});
            model(req_vaddr, req_write, req_priv, cfg_xlate_en, cfg_sq_lock, tlb_hit, tlb_multi,
                  tlb_user, tlb_wr, tlb_dirty, tlb_size, tlb_ppn, e_kind, e_pa, e_code, tag);
            if (e_code inside {4'd3, 4'd4, 4'd6, 4'd7, 4'd8}) begin
              exp_fault = req_vaddr;
              exp_pte = {req_vaddr[31:10], exp_pte[9:0]};
            end
            @(posedge clk); #1;
            chk("R12", "rsp_valid", {31'b0, rsp_valid}, 1);
            chk(tag, "rsp_kind", {30'b0, rsp_kind}, {30'b0, e_kind});
            chk(tag, "rsp_paddr", rsp_paddr, e_pa);
            chk(tag, "exc_code", {28'b0, exc_code}, {28'b0, e_code});
            chk("R12", "exc_strobe", {31'b0, exc_strobe}, {31'b0, e_code != 0});
            chk("R6", "exc_reset_class", {31'b0, exc_reset_class}, {31'b0, e_code == 4'd5});
            chk("R11", "fault_vaddr", fault_vaddr, exp_fault);
            chk("R11", "pte_hi", pte_hi, exp_pte);
            req_valid = 0;
          end
    // gap: no request -> no response next cycle
    @(negedge clk) req_valid = 0;
    @(posedge clk); #1;
    chk("R12", "gap rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R12", "gap exc_strobe", {31'b0, exc_strobe}, 0);
    chk("R12", "gap exc_code", {28'b0, exc_code}, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule